// File: doc/BRIEF.md
# Serial Registration-Code Checker

This block receives a 64-bit device registration code, one bit per accepted strobe, and checks it as it arrives. The code comes in least significant bit first. The block sorts each bit into one of three fields: an 8-bit family code, a 48-bit serial number and an 8-bit check byte. An 8-bit CRC runs over every accepted bit in parallel with the sorting.

When the sixty-fourth bit has been taken, the block raises a one-cycle completion pulse. At the same time it registers two verdicts. The first says whether the CRC residual is zero. The second says whether the family code equals the value set by a parameter.

A start pulse arms the receiver and clears all of its state. Strobes are taken only while the receiver is armed. It disarms itself after the last bit.

Top module: `romcode_check`

## Requirements
- R1: After reset, and in the cycle after a start pulse, familyCode, serialNum, crcByte, done, crcOk and familyMatch all read zero and the bit count restarts at zero.
- R2: Received bit i, for i from 0 to 7 in arrival order, appears at familyCode[i].
- R3: Received bit 8+j, for j from 0 to 47, appears at serialNum[j].
- R4: Received bit 56+k, for k from 0 to 7, appears at crcByte[k].
- R5: done is high for exactly one cycle, directly after the clock edge that samples the 64th accepted strobe. It is low at all other times.
- R6: crcOk is set with done. It is 1 exactly when the CRC register is zero after all 64 bits. The CRC register uses polynomial x^8+x^5+x^4+1, starts at zero, takes bits in arrival order and is updated as: feedback = crc[0] xor bit, crc shifts right, and crc is xored with 8'h8C when feedback is 1. crcOk holds its value until the next start.
- R7: familyMatch is set with done. It is 1 exactly when familyCode equals parameter EXP_FAMILY (default 8'h14). It holds its value until the next start.
- R8: Strobes after the 64th accepted bit and before the next start change no output.
- R9: Strobes after reset and before the first start change no output.
- R10: When a start pulse and a bit strobe arrive in the same cycle, the start takes effect and that strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | Arms the receiver and clears its state |
| bitValid | input | 1 | Strobe that qualifies bitData |
| bitData | input | 1 | Serial code bit |
| familyCode | output | 8 | Captured family field |
| serialNum | output | 48 | Captured serial field |
| crcByte | output | 8 | Captured check byte |
| done | output | 1 | One-cycle pulse after the 64th bit |
| crcOk | output | 1 | Zero CRC residual verdict |
| familyMatch | output | 1 | Expected-family verdict |

## Verification
Two functions can fall in the same cycle: the start pulse that clears the receiver, and a bit strobe that would shift a bit into a field. The bench raises both in one cycle with a 1 on the data line. It then checks that familyCode is still zero. It next sends a complete code and checks that every field and flag is correct, which would fail if the colliding bit had been counted. Separately, a start pulse issued right after a finished code must clear verdicts that had been set.

// File: rtl/romchk_pkg.sv
package romchk_pkg;
  typedef enum logic [1:0] {
    FLD_FAM = 2'd0,
    FLD_SER = 2'd1,
    FLD_CHK = 2'd2
  } fieldSel_e;

  typedef struct packed {
    logic      clear;
    logic      shift;
    fieldSel_e field;
    logic      last;
  } ctlStrobe_t;
endpackage

// File: rtl/romchk_ctrl.sv
module romchk_ctrl
  import romchk_pkg::*;
#(
  parameter int CODE_BITS = 64,
  parameter int FAM_BITS  = 8,
  parameter int SER_BITS  = 48
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       bitValid,
  output ctlStrobe_t ctl
);
  localparam int CNT_W = $clog2(CODE_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CODE_BITS - 1);
  localparam logic [CNT_W-1:0] SER_START = CNT_W'(FAM_BITS);
  localparam logic [CNT_W-1:0] CHK_START = CNT_W'(FAM_BITS + SER_BITS);

  logic [CNT_W-1:0] bitCount;
  logic             armed;

  always_comb begin
    ctl.clear = startPulse;
    ctl.shift = armed && bitValid && !startPulse;
    if (bitCount < SER_START)      ctl.field = FLD_FAM;
    else if (bitCount < CHK_START) ctl.field = FLD_SER;
    else                           ctl.field = FLD_CHK;
    ctl.last = ctl.shift && (bitCount == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount <= '0;
      armed    <= 1'b0;
    end else if (ctl.clear) begin
      bitCount <= '0;
      armed    <= 1'b1;
    end else if (ctl.shift) begin
      bitCount <= bitCount + 1'b1;
      if (ctl.last) armed <= 1'b0;
    end
  end

  // R8 / R9: with the receiver disarmed, no strobe moves the counter
  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!armed && !startPulse) |=> $stable(bitCount));

  // R10: a start always restarts counting, whatever the strobe does
  a_r10_start_wins: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> (bitCount == '0) && armed);

  // R5: the counter never passes the code length
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    bitCount <= CNT_W'(CODE_BITS));
endmodule

// File: rtl/romchk_dp.sv
module romchk_dp
  import romchk_pkg::*;
#(
  parameter int         FAM_BITS   = 8,
  parameter int         SER_BITS   = 48,
  parameter int         CHK_BITS   = 8,
  parameter logic [7:0] POLY_REV   = 8'h8C,
  parameter logic [7:0] EXP_FAMILY = 8'h14
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          ctl,
  input  logic                bitData,
  output logic [FAM_BITS-1:0] familyCode,
  output logic [SER_BITS-1:0] serialNum,
  output logic [CHK_BITS-1:0] crcByte,
  output logic                done,
  output logic                crcOk,
  output logic                familyMatch
);
  logic [CHK_BITS-1:0] crcState;
  logic [CHK_BITS-1:0] crcNext;
  logic                feedback;

  assign feedback = crcState[0] ^ bitData;

  genvar gi;
  generate
    for (gi = 0; gi < CHK_BITS; gi++) begin : g_crc
      if (gi == CHK_BITS - 1) begin : g_top
        assign crcNext[gi] = feedback & POLY_REV[gi];
      end else begin : g_mid
        assign crcNext[gi] = crcState[gi+1] ^ (feedback & POLY_REV[gi]);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      familyCode  <= '0;
      serialNum   <= '0;
      crcByte     <= '0;
      crcState    <= '0;
      done        <= 1'b0;
      crcOk       <= 1'b0;
      familyMatch <= 1'b0;
    end else if (ctl.clear) begin
      familyCode  <= '0;
      serialNum   <= '0;
      crcByte     <= '0;
      crcState    <= '0;
      done        <= 1'b0;
      crcOk       <= 1'b0;
      familyMatch <= 1'b0;
    end else begin
      done <= ctl.last;
      if (ctl.shift) begin
        crcState <= crcNext;
        unique case (ctl.field)
          FLD_FAM: familyCode <= {bitData, familyCode[FAM_BITS-1:1]};
          FLD_SER: serialNum  <= {bitData, serialNum[SER_BITS-1:1]};
          default: crcByte    <= {bitData, crcByte[CHK_BITS-1:1]};
        endcase
      end
      if (ctl.last) begin
        crcOk       <= (crcNext == '0);
        familyMatch <= (familyCode == EXP_FAMILY);
      end
    end
  end

  // R5: completion is a single-cycle pulse
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6 / R7: verdicts move only on the last bit or on a start
  a_r6_flags_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.last && !ctl.clear) |=> ($stable(crcOk) && $stable(familyMatch)));

  // R1: a start leaves every field and verdict cleared
  a_r1_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> (familyCode == '0 && serialNum == '0 && crcByte == '0
                   && !crcOk && !familyMatch && !done));

  // R7: a matching verdict implies the held family equals the expected one
  a_r7_match_family: assert property (@(posedge clk) disable iff (!rstN)
    familyMatch |-> (familyCode == EXP_FAMILY));
endmodule

// File: rtl/romcode_check.sv
module romcode_check
  import romchk_pkg::*;
#(
  parameter logic [7:0] EXP_FAMILY = 8'h14,
  parameter int         FAM_BITS   = 8,
  parameter int         SER_BITS   = 48,
  parameter int         CHK_BITS   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startPulse,
  input  logic                bitValid,
  input  logic                bitData,
  output logic [FAM_BITS-1:0] familyCode,
  output logic [SER_BITS-1:0] serialNum,
  output logic [CHK_BITS-1:0] crcByte,
  output logic                done,
  output logic                crcOk,
  output logic                familyMatch
);
  localparam int CODE_BITS = FAM_BITS + SER_BITS + CHK_BITS;

  ctlStrobe_t ctl;

  romchk_ctrl #(
    .CODE_BITS(CODE_BITS),
    .FAM_BITS (FAM_BITS),
    .SER_BITS (SER_BITS)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .bitValid  (bitValid),
    .ctl       (ctl)
  );

  romchk_dp #(
    .FAM_BITS  (FAM_BITS),
    .SER_BITS  (SER_BITS),
    .CHK_BITS  (CHK_BITS),
    .POLY_REV  (8'h8C),
    .EXP_FAMILY(EXP_FAMILY)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .bitData    (bitData),
    .familyCode (familyCode),
    .serialNum  (serialNum),
    .crcByte    (crcByte),
    .done       (done),
    .crcOk      (crcOk),
    .familyMatch(familyMatch)
  );
endmodule

// File: tb/sim_romcode_check.sv
module sim_romcode_check;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic        bitValid = 1'b0;
  logic        bitData = 1'b0;
  logic [7:0]  familyCode;
  logic [47:0] serialNum;
  logic [7:0]  crcByte;
  logic        done;
  logic        crcOk;
  logic        familyMatch;

  int nChecks = 0;
  int nFails = 0;
  bit earlyDone;

  always #5 clk = ~clk;

  romcode_check u0 (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .bitValid(bitValid),
    .bitData(bitData), .familyCode(familyCode), .serialNum(serialNum),
    .crcByte(crcByte), .done(done), .crcOk(crcOk), .familyMatch(familyMatch)
  );

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: act=timeout exp=completion");
    finishRun();
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] crcOf(logic [55:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      logic fb = c[0] ^ d[i];
      c = {1'b0, c[7:1]};
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  function automatic logic [63:0] buildCode(logic [7:0] fam, logic [47:0] ser);
    logic [55:0] body = {ser, fam};
    return {crcOf(body), body};
  endfunction

  task automatic doStart();
    @(negedge clk);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic sendBit(logic b);
    @(negedge clk);
    bitValid = 1'b1;
    bitData  = b;
    @(negedge clk);
    bitValid = 1'b0;
    bitData  = 1'b0;
  endtask

  task automatic sendBody(logic [63:0] code, int nBits);
    earlyDone = 1'b0;
    for (int i = 0; i < nBits; i++) begin
      sendBit(code[i]);
      if (i < 63 && done) earlyDone = 1'b1;
    end
  endtask

  task automatic checkCode(string tag, logic [63:0] code, logic expCrc, logic expFam);
    sendBody(code, 64);
    chk({tag, " R5 no early done"}, {63'd0, earlyDone}, 64'd0);
    chk({tag, " R5 done"}, {63'd0, done}, 64'd1);
    chk({tag, " R2 family"}, {56'd0, familyCode}, {56'd0, code[7:0]});
    chk({tag, " R3 serial"}, {16'd0, serialNum}, {16'd0, code[55:8]});
    chk({tag, " R4 crcByte"}, {56'd0, crcByte}, {56'd0, code[63:56]});
    chk({tag, " R6 crcOk"}, {63'd0, crcOk}, {63'd0, expCrc});
    chk({tag, " R7 familyMatch"}, {63'd0, familyMatch}, {63'd0, expFam});
    @(negedge clk);
    chk({tag, " R5 done drops"}, {63'd0, done}, 64'd0);
    chk({tag, " R6 crcOk held"}, {63'd0, crcOk}, {63'd0, expCrc});
    chk({tag, " R7 match held"}, {63'd0, familyMatch}, {63'd0, expFam});
  endtask

  task automatic checkCleared(string tag);
    chk({tag, " R1 family"}, {56'd0, familyCode}, 64'd0);
    chk({tag, " R1 serial"}, {16'd0, serialNum}, 64'd0);
    chk({tag, " R1 crcByte"}, {56'd0, crcByte}, 64'd0);
    chk({tag, " R1 flags"}, {61'd0, done, crcOk, familyMatch}, 64'd0);
  endtask

  task automatic tResetState();
    checkCleared("reset");
  endtask

  task automatic tBeforeStart();
    sendBody(64'hFFFF_FFFF_FFFF_FFFF, 64);
    chk("R9 no done before start", {63'd0, earlyDone | done}, 64'd0);
    checkCleared("R9 before start");
  endtask

  task automatic tGoodCode();
    logic [47:0] ser = {$urandom(), $urandom()};
    doStart();
    checkCode("good", buildCode(8'h14, ser), 1'b1, 1'b1);
  endtask

  task automatic tBadCrc();
    logic [47:0] ser = {$urandom(), $urandom()};
    logic [63:0] code = buildCode(8'h14, ser);
    code[56 + ($urandom() % 8)] ^= 1'b1;
    doStart();
    checkCode("badcrc", code, 1'b0, 1'b1);
  endtask

  task automatic tBadSerialBit();
    logic [47:0] ser = {$urandom(), $urandom()};
    logic [63:0] code = buildCode(8'h14, ser);
    code[8 + ($urandom() % 48)] ^= 1'b1;
    doStart();
    checkCode("badser", code, 1'b0, 1'b1);
  endtask

  task automatic tWrongFamily();
    logic [47:0] ser = {$urandom(), $urandom()};
    doStart();
    checkCode("wrongfam", buildCode(8'h28, ser), 1'b1, 1'b0);
  endtask

  task automatic tPartialAndRestart();
    logic [63:0] code = buildCode(8'h14, 48'h1234_5678_9ABC);
    doStart();
    sendBody(code, 30);
    chk("R5 partial no done", {63'd0, earlyDone | done}, 64'd0);
    chk("R6 partial flags low", {62'd0, crcOk, familyMatch}, 64'd0);
    chk("R2 partial family", {56'd0, familyCode}, {56'd0, code[7:0]});
    doStart();
    checkCleared("R1 restart mid code");
    checkCode("after restart", code, 1'b1, 1'b1);
  endtask

  task automatic tIgnoreAfter();
    logic [63:0] code = buildCode(8'h14, 48'hA5A5_0F0F_3C3C);
    doStart();
    checkCode("pre-ignore", code, 1'b1, 1'b1);
    earlyDone = 1'b0;
    for (int i = 0; i < 10; i++) begin
      sendBit(i[0]);
      if (done) earlyDone = 1'b1;
    end
    chk("R8 no done after end", {63'd0, earlyDone}, 64'd0);
    chk("R8 family kept", {56'd0, familyCode}, {56'd0, code[7:0]});
    chk("R8 serial kept", {16'd0, serialNum}, {16'd0, code[55:8]});
    chk("R8 crcByte kept", {56'd0, crcByte}, {56'd0, code[63:56]});
    chk("R8 flags kept", {62'd0, crcOk, familyMatch}, 64'd3);
    doStart();
    checkCleared("R1 start after done");
  endtask

  task automatic tCollision();
    logic [63:0] code = buildCode(8'h14, 48'h0000_FFFF_8001);
    @(negedge clk);
    startPulse = 1'b1;
    bitValid   = 1'b1;
    bitData    = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    bitValid   = 1'b0;
    bitData    = 1'b0;
    chk("R10 colliding bit dropped", {56'd0, familyCode}, 64'd0);
    checkCode("R10 code after collision", code, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tResetState();
    tBeforeStart();
    tGoodCode();
    tGoodCode();
    tBadCrc();
    tBadSerialBit();
    tWrongFamily();
    tPartialAndRestart();
    tIgnoreAfter();
    tCollision();
    tGoodCode();
    finishRun();
  end
endmodule